// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock and asks for a system reset unless software keeps it alive. A 12-bit down-counter is decremented once per prescaled slow-clock tick. When it reaches zero, the block drives a reset request for a fixed number of slow-clock cycles. Software reaches the block through a small register bus on the fast clock. Special 16-bit values written to a key register start the timer, refresh it, and open the configuration registers for writing.

Configuration values and key commands cross into the slow domain through toggle handshakes with two-flop synchronizers. Status bits stay set while a prescaler or reload update is still on its way across. Once the timer is running, nothing written over the bus can stop it. A debug-halt input, qualified by a freeze enable, can pause the count. A sticky cause flag records that the watchdog asked for a reset. It is cleared only by software or by the power-on reset. The integrator ties that reset to `rst_n`, not to the watchdog's own request.

Register map (word address on `bus_addr`): 0 = key (write only), 1 = prescaler code (bits 2:0), 2 = reload value (bits 11:0), 3 = status (bit 0 prescaler update busy, bit 1 reload update busy, bit 2 watchdog reset cause; write 1 to bit 2 to clear it).

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n`, the counter holds 0xFFF. The prescaler code reads 0, the reload value reads 0xFFF, the status reads 0 and `wdg_rst_req` is low. The timer is idle unless `hw_start` was high during reset.
- R2: Writing key 0xCCCC starts the timer, and so does `hw_start` being high during reset. Once running, no key or register write stops it. From reset with `hw_start` high, the request rises about 4×4095+1 slow cycles later.
- R3: Writing key 0xAAAA loads the reload value into the counter and restarts the prescaler phase. With reload R and divide ratio D on a running timer, `wdg_rst_req` rises on the (4 + R×D)-th slow-clock rising edge after the bus edge that wrote the key. This includes R = 0.
- R4: Prescaler code c (0..6) selects a divide ratio D = 4·2^c. Code 7 also selects 256.
- R5: Key 0x5555 unlocks writes to the prescaler and reload registers. While locked, writes to them are ignored. Any key other than 0x5555, 0xAAAA or 0xCCCC locks them again.
- R6: An accepted prescaler or reload write sets its busy bit (status bit 0 or bit 1). The bit clears once the slow domain has acknowledged the value, within a few slow cycles. A write to that register while its busy bit is set is ignored.
- R7: While `dbg_halt` and `freeze_en` are both high, the counter holds its value. With `freeze_en` low, `dbg_halt` has no effect on the timing of R3.
- R8: The reset request lasts exactly PULSE_LEN (default 4) slow cycles. Afterwards the counter is back at 0xFFF and keeps running.
- R9: A reset request sets the cause flag (status bit 2 and `wdg_cause`). The flag stays set until software writes 1 to status bit 2.
- R10: A refresh key while the timer is idle loads the counter but never causes a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset for both domains |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| slow_clk | input | 1 | Independent slow timer clock |
| dbg_halt | input | 1 | Core halted in debug |
| freeze_en | input | 1 | Allows `dbg_halt` to pause the count |
| hw_start | input | 1 | Strap: start at reset without software |
| wdg_rst_req | output | 1 | Reset request pulse, slow-clock domain |
| wdg_cause | output | 1 | Sticky watchdog-reset cause flag |

## Verification
A key or register write is registered on its bus edge. It passes two synchronizer flops and an edge-detect flop, so it takes effect on the third slow edge after the write. The expiry flop then puts the request up on slow edge 4 + R×D. The bench counts slow edges from the write and samples one time unit after each edge. The bench clocks are phased so that no slow edge falls on a bus edge, which makes that count exact up to a tolerance of one. Busy bits read as set on the bus cycle after a write and are polled until they clear. The cause flag is read a few bus cycles after the request rises, to cover its three-flop synchronizer.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_W     = 12,
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        slow_clk,
  input  logic        dbg_halt,
  input  logic        freeze_en,
  input  logic        hw_start,
  output logic        wdg_rst_req,
  output logic        wdg_cause
);
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // handshake lanes: 0 prescaler, 1 reload value, 2 refresh, 3 start
  logic [3:0] tog, ack1, ack2, s1, s2, s3;
  logic [2:0] pr_q, pr_s;
  logic [CNT_W-1:0] rlr_q, rlr_s, cnt;
  logic unlocked, cause, rq1, rq2, rq3;
  logic running, h1, h2, f1, f2;
  logic [7:0] pcnt;
  logic [PW-1:0] pulse_cnt;

  // ---------------- bus domain ----------------
  wire        key_wr = bus_we && bus_addr == 2'd0;
  wire [3:0]  pend   = tog ^ ack2;
  wire [3:0]  fire;
  assign fire[0] = bus_we && bus_addr == 2'd1 && unlocked && !pend[0];
  assign fire[1] = bus_we && bus_addr == 2'd2 && unlocked && !pend[1];
  assign fire[2] = key_wr && bus_wdata == KEY_REFRESH && !pend[2];
  assign fire[3] = key_wr && bus_wdata == KEY_START && !pend[3];
  wire cause_clr = bus_we && bus_addr == 2'd3 && bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tog <= '0; ack1 <= '0; ack2 <= '0;
      pr_q <= '0; rlr_q <= CNT_TOP; unlocked <= 1'b0;
      rq1 <= 1'b0; rq2 <= 1'b0; rq3 <= 1'b0; cause <= 1'b0;
    end else begin
      tog  <= tog ^ fire;
      ack1 <= s3;
      ack2 <= ack1;
      if (fire[0]) pr_q  <= bus_wdata[2:0];
      if (fire[1]) rlr_q <= bus_wdata[CNT_W-1:0];
      if (key_wr) begin
        if (bus_wdata == KEY_UNLOCK) unlocked <= 1'b1;
        else if (bus_wdata != KEY_REFRESH && bus_wdata != KEY_START) unlocked <= 1'b0;
      end
      rq1 <= wdg_rst_req; rq2 <= rq1; rq3 <= rq2;
      if (rq2 && !rq3) cause <= 1'b1;
      else if (cause_clr) cause <= 1'b0;
    end

  always_comb
    case (bus_addr)
      2'd1:    bus_rdata = {13'd0, pr_q};
      2'd2:    bus_rdata = {{(16-CNT_W){1'b0}}, rlr_q};
      2'd3:    bus_rdata = {13'd0, cause, pend[1], pend[0]};
      default: bus_rdata = 16'd0;
    endcase

  assign wdg_cause = cause;

  // ---------------- slow domain ----------------
  wire [3:0] evt    = s2 ^ s3;
  wire [2:0] code   = (pr_s == 3'd7) ? 3'd6 : pr_s;
  wire [8:0] div    = 9'd4 << code;
  wire [7:0] div_m1 = div[7:0] - 8'd1;
  wire       frozen = h2 && f2;
  wire       active = running && !frozen && pulse_cnt == '0;
  wire       tick   = active && pcnt == div_m1;

  always_ff @(posedge slow_clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      h1 <= 1'b0; h2 <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
      pr_s <= '0; rlr_s <= CNT_TOP; running <= hw_start;
      cnt <= CNT_TOP; pcnt <= '0; pulse_cnt <= '0;
    end else begin
      s1 <= tog; s2 <= s1; s3 <= s2;
      h1 <= dbg_halt; h2 <= h1; f1 <= freeze_en; f2 <= f1;
      if (evt[0]) pr_s  <= pr_q;
      if (evt[1]) rlr_s <= rlr_q;
      if (evt[3]) running <= 1'b1;
      if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - PW'(1);
        if (pulse_cnt == PW'(1)) begin
          cnt  <= CNT_TOP;
          pcnt <= '0;
        end
      end else if (evt[2]) begin
        cnt  <= evt[1] ? rlr_q : rlr_s;
        pcnt <= '0;
      end else if (running && cnt == '0) begin
        pulse_cnt <= PW'(PULSE_LEN);
      end else begin
        if (evt[0]) pcnt <= '0;
        else if (active) pcnt <= tick ? 8'd0 : pcnt + 8'd1;
        if (tick) cnt <= cnt - CNT_ONE;
      end
    end

  assign wdg_rst_req = pulse_cnt != '0;

  // ---------------- assertions ----------------
  AST_RUN_STICKY: assert property (@(posedge slow_clk) disable iff (!rst_n) running |=> running); // R2
  AST_REQ_NEEDS_RUN: assert property (@(posedge slow_clk) disable iff (!rst_n) wdg_rst_req |-> running); // R10
  AST_FREEZE_HOLD: assert property (@(posedge slow_clk) disable iff (!rst_n) frozen && pulse_cnt == '0 && !evt[2] |=> $stable(cnt)); // R7
  AST_PULSE_RELOADS_TOP: assert property (@(posedge slow_clk) disable iff (!rst_n) $fell(wdg_rst_req) |-> cnt == CNT_TOP); // R8
  AST_LOCKED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) !unlocked |=> $stable(rlr_q)); // R5
  AST_BUSY_PR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) pend[0] |=> $stable(pr_q)); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cause && !cause_clr |=> cause); // R9
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic dbg_halt = 1'b0, freeze_en = 1'b0, hw_start = 1'b0;
  logic wdg_rst_req, wdg_cause;
  int checks = 0, failures = 0;

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_clk(slow_clk),
    .dbg_halt(dbg_halt), .freeze_en(freeze_en), .hw_start(hw_start),
    .wdg_rst_req(wdg_rst_req), .wdg_cause(wdg_cause)
  );

  always #2 clk = ~clk;               // 250 MHz
  initial begin #1; forever #8 slow_clk = ~slow_clk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic wait_idle(output int n);
    int v;
    n = 0;
    rd(2'd3, v);
    while ((v & 3) != 0 && n < 200) begin n++; rd(2'd3, v); end
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge slow_clk); #1; n++;
      if (wdg_rst_req) break;
    end
  endtask

  task automatic wait_low();
    while (wdg_rst_req) @(posedge slow_clk);
    #1;
  endtask

  task automatic slow_wait(input int k);
    repeat (k) @(posedge slow_clk);
    #1;
  endtask

  initial begin
    #760000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, n, seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(wdg_rst_req == 1'b0, "R1 req low", wdg_rst_req, 0);
    rd(2'd3, v); check(v == 0, "R1 status", v, 0);
    rd(2'd1, v); check(v == 0, "R1 prescaler", v, 0);
    rd(2'd2, v); check(v == 12'hFFF, "R1 reload", v, 12'hFFF);

    // R5 locked writes ignored
    wr(2'd2, 16'd5); rd(2'd2, v); check(v == 12'hFFF, "R5 locked reload", v, 12'hFFF);
    wr(2'd1, 16'd3); rd(2'd1, v); check(v == 0, "R5 locked prescaler", v, 0);

    // R6 busy set, write while busy ignored, busy clears
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd0);
    rd(2'd3, v); check((v & 2) == 2, "R6 reload busy set", v & 2, 2);
    wr(2'd2, 16'd7);
    rd(2'd2, v); check(v == 0, "R6 write while busy ignored", v, 0);
    wait_idle(n); check(n < 40, "R6 busy clears", n, 40);

    // R10 refresh while idle never expires
    wr(2'd0, 16'hAAAA);
    seen = 0;
    repeat (40) begin @(posedge slow_clk); #1; if (wdg_rst_req) seen = 1; end
    check(seen == 0, "R10 idle no request", seen, 0);

    // R2 start key, counter already zero
    wr(2'd0, 16'hCCCC);
    measure(100, n); check(n == 4, "R2 start then expire", n, 4);
    // R8 pulse width
    seen = 0;
    while (wdg_rst_req) begin seen++; @(posedge slow_clk); #1; end
    check(seen == 4, "R8 pulse width", seen, 4);
    // R9 cause flag
    repeat (6) @(negedge clk);
    rd(2'd3, v); check((v & 4) == 4 && wdg_cause, "R9 cause set", v & 4, 4);
    wr(2'd3, 16'h0004);
    rd(2'd3, v); check((v & 4) == 0 && !wdg_cause, "R9 cause cleared", v & 4, 0);
    // R8 counter back at top: no request soon after
    seen = 0;
    repeat (200) begin @(posedge slow_clk); #1; if (wdg_rst_req) seen = 1; end
    check(seen == 0, "R8 top after pulse", seen, 0);

    // R5 relock on other key; R2 stray keys do not stop the timer
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'd9); rd(2'd2, v); check(v == 0, "R5 relocked", v, 0);
    wr(2'd0, 16'h0000);

    // R3 R4 sweep over prescaler codes and reload values
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 6; r += (r == 2) ? 3 : 1) begin
        int d;
        int exp_n;
        d = (c == 7) ? 256 : (4 << c);
        exp_n = 4 + r * d;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(c));
        wr(2'd2, 16'(r));
        wait_idle(n);
        rd(2'd1, v); check(v == c, "R4 prescaler readback", v, c);
        wr(2'd0, 16'hAAAA);
        measure(3000, n);
        check(n >= exp_n - 1 && n <= exp_n + 1, $sformatf("R3 R4 code%0d reload%0d", c, r), n, exp_n);
        wait_low();
      end
    end

    // R7 freeze
    wr(2'd0, 16'h5555); wr(2'd1, 16'd0); wr(2'd2, 16'd1); wait_idle(n);
    freeze_en = 1'b1; dbg_halt = 1'b1; slow_wait(4);
    wr(2'd0, 16'hAAAA);
    seen = 0;
    repeat (60) begin @(posedge slow_clk); #1; if (wdg_rst_req) seen = 1; end
    check(seen == 0, "R7 frozen holds", seen, 0);
    dbg_halt = 1'b0;
    measure(100, n); check(n >= 1 && n <= 20, "R7 resumes after halt", n, 8);
    wait_low();
    freeze_en = 1'b0; dbg_halt = 1'b1; slow_wait(4);
    wr(2'd0, 16'hAAAA);
    measure(100, n); check(n >= 7 && n <= 9, "R7 halt ignored when freeze off", n, 8);
    wait_low();
    dbg_halt = 1'b0;

    // R2 hardware start strap
    @(negedge clk); hw_start = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd3, v); check(v == 0, "R1 status after second reset", v, 0);
    measure(20000, n);
    check(n >= 16378 && n <= 16384, "R2 strap start timeout", n, 16381);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule